// File: doc/BRIEF.md
# Write Streaming Allocation Controller

This block sits beside a cache's write-miss path and decides, line by line, whether a write miss that would normally allocate should be kept out of the L1 cache, out of both L1 and L2, or allocated as usual. It tracks runs of full-line writes to ascending, adjacent line addresses. Once a run grows long enough, the data is assumed to be streaming and unlikely to be reused, so allocating it would only evict useful lines.

Two independent 2-bit configuration fields set the run length at which suppression starts. The first, `cfg_both`, governs suppression in both caches. The second, `cfg_l1`, governs suppression in L1 alone. Each field has one code that turns its suppression off. The decision is registered and appears on two flags one clock after the miss strobe. The flags hold that value until the next miss.

Top module: `wstream_alloc_ctl`

## Requirements
- R1: After reset the run count is zero and both `skip_l1` and `skip_l2` are 0.
- R2: A write miss with `miss_full`=1 extends the run by one when the run is nonzero and `miss_addr` equals the previous miss address plus 1. The first full-line miss after reset or after a break gives a run of 1.
- R3: A full-line miss whose address is not the previous address plus 1 restarts the run at 1. This includes a repeat of the same address.
- R4: A miss with `miss_full`=0 sets the run to 0 and produces `skip_l1`=0 and `skip_l2`=0. The next full-line miss then starts a new run at 1, whatever its address.
- R5: With `cfg_both` at 0, 1 or 2, both flags are 1 for a miss whose run count is at least 16, 128 or 512 respectively, and `skip_l2` is 0 below that count. The reset-time setting is 1, giving 128.
- R6: With `cfg_both`=3, `skip_l2` is always 0.
- R7: With `cfg_l1` at 0, 1 or 2, `skip_l1` is 1 for a run count of at least 4, 64 or 128 respectively. This field never affects `skip_l2`. The reset-time setting is 0, giving 4.
- R8: With `cfg_l1`=3, `skip_l1` equals `skip_l2`.
- R9: The run count saturates at 512. A stream of any length stays suppressed from its threshold onward and never wraps back to an allocating state.
- R10: Both flags change only in the cycle after a strobe. The configuration fields are sampled with the strobe, so changing them between misses leaves the flags untouched until the next miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_vld | input | 1 | One-cycle strobe for an allocating write miss |
| miss_addr | input | ADDR_W | Line address of the miss (increments by 1 per line) |
| miss_full | input | 1 | The whole line is written by this miss |
| cfg_both | input | 2 | Threshold code for suppressing L1 and L2 allocation: 0=16, 1=128, 2=512, 3=off |
| cfg_l1 | input | 2 | Threshold code for suppressing L1 allocation only: 0=4, 1=64, 2=128, 3=off |
| skip_l1 | output | 1 | Do not allocate the last miss's line in L1 |
| skip_l2 | output | 1 | Do not allocate the last miss's line in L2 |

## Verification
The hardest states to reach are the far end of the run counter: the 512-line threshold and the saturation point beyond it. No short test gets there, and a counter that wraps only shows its fault after roughly a thousand adjacent lines. The bench drives every one of the sixteen configuration pairs through a 600-line adjacent stream, comparing each line against an arithmetic threshold model. It then runs a single 1100-line stream, which carries the count well past the width at which an unsaturated counter would wrap.

// File: rtl/wstream_alloc_ctl.sv
module wstream_alloc_ctl #(
  parameter int ADDR_W  = 26,
  parameter int CNT_SAT = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_vld,
  input  logic [ADDR_W-1:0] miss_addr,
  input  logic              miss_full,
  input  logic [1:0]        cfg_both,
  input  logic [1:0]        cfg_l1,
  output logic              skip_l1,
  output logic              skip_l2
);
  localparam int CW = $clog2(CNT_SAT + 1);

  logic [CW-1:0]     run_q, run_d;
  logic [ADDR_W-1:0] last_q;
  logic              l1_q, l2_q;

  function automatic int lim_both(input logic [1:0] c);
    case (c)
      2'd0:    return 16;
      2'd1:    return 128;
      default: return 512;
    endcase
  endfunction

  function automatic int lim_l1(input logic [1:0] c);
    case (c)
      2'd0:    return 4;
      2'd1:    return 64;
      default: return 128;
    endcase
  endfunction

  wire adjacent = (run_q != '0) && (miss_addr == last_q + ADDR_W'(1));

  always_comb begin
    if (!miss_full)                 run_d = '0;
    else if (!adjacent)             run_d = CW'(1);
    else if (run_q == CW'(CNT_SAT)) run_d = run_q;
    else                            run_d = run_q + CW'(1);
  end

  wire hit_both = (cfg_both != 2'd3) && (int'(run_d) >= lim_both(cfg_both));
  wire hit_l1   = (cfg_l1   != 2'd3) && (int'(run_d) >= lim_l1(cfg_l1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= '0;
      last_q <= '0;
      l1_q   <= 1'b0;
      l2_q   <= 1'b0;
    end else if (miss_vld) begin
      run_q  <= run_d;
      last_q <= miss_addr;
      l2_q   <= hit_both;
      l1_q   <= hit_both | hit_l1;
    end
  end

  assign skip_l1 = l1_q;
  assign skip_l2 = l2_q;

  AST_RUN_CAP: assert property (@(posedge clk) disable iff (!rst_n) int'(run_q) <= CNT_SAT); // R9
  AST_L2_IMPLIES_L1: assert property (@(posedge clk) disable iff (!rst_n) skip_l2 |-> skip_l1); // R5
  AST_PARTIAL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (miss_vld && !miss_full) |=> (!skip_l1 && !skip_l2)); // R4
  AST_BOTH_OFF: assert property (@(posedge clk) disable iff (!rst_n) (miss_vld && cfg_both == 2'd3) |=> !skip_l2); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !miss_vld |=> ($stable(skip_l1) && $stable(skip_l2))); // R10
endmodule

// File: tb/wstream_alloc_ctl_bench.sv
module wstream_alloc_ctl_bench;
  localparam int AW = 26;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          miss_vld = 1'b0;
  logic [AW-1:0] miss_addr = '0;
  logic          miss_full = 1'b0;
  logic [1:0]    cfg_both = 2'd1;
  logic [1:0]    cfg_l1 = 2'd0;
  logic          skip_l1, skip_l2;

  int n_chk = 0, n_bad = 0;
  int mcnt = 0;
  int mlast = 0;

  always #5 clk = ~clk;

  wstream_alloc_ctl #(.ADDR_W(AW), .CNT_SAT(512)) u_wstream_alloc_ctl (
    .clk, .rst_n, .miss_vld, .miss_addr, .miss_full, .cfg_both, .cfg_l1, .skip_l1, .skip_l2
  );

  function automatic int tb_lim_both(int c);
    return (c == 0) ? 16 : (c == 1) ? 128 : (c == 2) ? 512 : 1 << 30;
  endfunction
  function automatic int tb_lim_l1(int c);
    return (c == 0) ? 4 : (c == 1) ? 64 : (c == 2) ? 128 : 1 << 30;
  endfunction

  task automatic check(string tag, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0b expected=%0b (run=%0d)", tag, what, act, exp, mcnt);
    end
  endtask

  task automatic miss(int addr, bit full, string tag);
    bit e1, e2;
    string t1, t2;
    @(negedge clk);
    miss_vld = 1'b1; miss_addr = AW'(addr); miss_full = full;
    if (!full) mcnt = 0;
    else if (mcnt != 0 && addr == mlast + 1) mcnt = (mcnt < 512) ? mcnt + 1 : 512;
    else mcnt = 1;
    mlast = addr;
    e2 = (mcnt >= tb_lim_both(int'(cfg_both)));
    e1 = e2 || (mcnt >= tb_lim_l1(int'(cfg_l1)));
    t2 = (tag != "") ? tag : (cfg_both == 2'd3) ? "R6" : "R5";
    t1 = (tag != "") ? tag : (cfg_l1 == 2'd3) ? "R8" : "R7";
    @(negedge clk);
    miss_vld = 1'b0;
    check(t1, "skip_l1", skip_l1, e1);
    check(t2, "skip_l2", skip_l2, e2);
  endtask

  initial begin
    #1_500_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "skip_l1", skip_l1, 1'b0);
    check("R1", "skip_l2", skip_l2, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "skip_l1", skip_l1, 1'b0);
    check("R1", "skip_l2", skip_l2, 1'b0);

    // R2: reset-time codes (128 both, 4 L1); adjacent stream
    for (int i = 0; i < 10; i++) miss(100 + i, 1'b1, "R2");

    // R3: a jump and a repeat both restart at 1
    miss(500, 1'b1, "R3");
    for (int i = 1; i < 5; i++) miss(500 + i, 1'b1, "R3");
    miss(504, 1'b1, "R3");
    miss(505, 1'b1, "R3");

    // R4: partial write clears, next full miss starts at 1
    for (int i = 0; i < 6; i++) miss(700 + i, 1'b1, "R4");
    miss(706, 1'b0, "R4");
    miss(707, 1'b1, "R4");
    miss(708, 1'b1, "R4");

    // R10: flags hold across idle cycles and a config change
    for (int i = 0; i < 5; i++) miss(900 + i, 1'b1, "R10");
    cfg_both = 2'd3; cfg_l1 = 2'd3;
    repeat (3) @(negedge clk);
    check("R10", "skip_l1 hold", skip_l1, 1'b1);
    check("R10", "skip_l2 hold", skip_l2, 1'b0);
    miss(905, 1'b1, "R10");

    // R5 R6 R7 R8: sweep every configuration pair
    for (int cb = 0; cb < 4; cb++) begin
      for (int cl = 0; cl < 4; cl++) begin
        cfg_both = 2'(cb); cfg_l1 = 2'(cl);
        miss(10, 1'b0, "R4");
        for (int i = 0; i < 600; i++) miss(20000 + cb * 4000 + cl * 1000 + i, 1'b1, "");
      end
    end

    // R9: a long stream beyond counter wrap width stays suppressed
    cfg_both = 2'd2; cfg_l1 = 2'd3;
    miss(10, 1'b0, "R4");
    for (int i = 0; i < 1100; i++) miss(100000 + i, 1'b1, (i >= 511) ? "R9" : "");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule